// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block records which cache lines one logical processor has loaded from and stored to while a transactional region is open. It also watches the snoop traffic from other agents and aborts the region when a remote access collides with that footprint. The core opens a region with a begin pulse. It closes the region with a commit pulse or with one of two abort requests. One abort request comes from the core itself and one comes from an external event source. While the region is open, each transactional load or store presents an address. The tracker drops the offset within the line and places the line tag into the read set or the write set.

The collision check is asymmetric. A remote read collides only with a line in the local write set. A remote write collides with a line in either set. Each set has a fixed number of fully associative entries. When a new line does not fit, the region aborts with a capacity cause and no entry is evicted. Every commit or abort empties both sets in a single cycle and pulses a clear indication. An abort also pulses a strobe and drives a 2-bit cause code.

Accesses and snoops carry a valid bit and are accepted in every cycle they are presented. There is no back-pressure, so neither channel has a ready signal. All outputs are registered and change on the clock edge that samples the event.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset, abort_pulse and end_clear are 0 and no region is open.
- R2: While a region is open, a remote read whose line is in the write set sets abort_pulse to 1 one cycle later with abort_cause 2'b00 (conflict).
- R3: A remote read whose line is only in the read set causes no abort.
- R4: While a region is open, a remote write whose line is in the read set or the write set aborts one cycle later with abort_cause 2'b00.
- R5: Lines are compared on address bits [AW-1:LINE_BITS] only. With LINE_BITS=6, two addresses in the same 64-byte line collide, and addresses in adjacent lines do not.
- R6: A new line that would be entry ENTRIES+1 of its set aborts with abort_cause 2'b01 (capacity). An access to a line already in its set uses no new entry.
- R7: An external abort request gives abort_cause 2'b10. An explicit core abort request gives abort_cause 2'b11.
- R8: A commit or an abort closes the region, empties both sets and sets end_clear to 1 for exactly one cycle. abort_pulse is 1 only for an abort. A later region does not collide with lines from an earlier region.
- R9: While no region is open, snoops, local accesses, commits and abort requests are ignored. Nothing is recorded and no output pulses. A begin while a region is open is ignored.
- R10: A colliding snoop in the same cycle as a commit produces a conflict abort instead of a commit.
- R11: When several abort reasons occur in the same cycle, the reported cause follows the priority conflict > capacity > external > explicit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_begin | input | 1 | Open a region (ignored if one is open) |
| txn_commit | input | 1 | Close the region successfully |
| txn_abort_req | input | 1 | Explicit abort from the core |
| txn_abort_ext | input | 1 | Abort from an external event |
| acc_valid | input | 1 | Transactional local access present |
| acc_write | input | 1 | 1 = store (write set), 0 = load (read set) |
| acc_addr | input | AW | Local access byte address |
| snp_valid | input | 1 | Remote snoop present |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | AW | Snoop byte address |
| abort_pulse | output | 1 | One-cycle abort strobe |
| abort_cause | output | 2 | 00 conflict, 01 capacity, 10 external, 11 explicit |
| end_clear | output | 1 | One-cycle pulse: both sets were emptied |

## Verification
The bench uses the default parameters: AW=32, LINE_BITS=6 and ENTRIES=16. With 64-byte lines, the bench can place addresses a few bytes apart inside one line and also in adjacent lines. With 16 entries, the capacity limit is reached after seventeen distinct loads, which is short enough to reach directly. The stimulus table also covers the asymmetric snoop rules, the commit race and the priority between abort reasons in the same cycle.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [1:0] {
    CAUSE_CONFLICT = 2'b00,
    CAUSE_CAPACITY = 2'b01,
    CAUSE_EXTERNAL = 2'b10,
    CAUSE_EXPLICIT = 2'b11
  } abort_cause_e;
endpackage

// File: rtl/txn_line_set.sv
// Fully associative set of line tags with per-entry valid bits.
module txn_line_set #(
  parameter int ENTRIES = 16,
  parameter int TAGW    = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ins_en,
  input  logic [TAGW-1:0] ins_tag,
  input  logic [TAGW-1:0] probe_tag,
  output logic            probe_hit,
  output logic            ins_present,
  output logic            full
);
  logic [ENTRIES-1:0]           vld;
  logic [ENTRIES-1:0][TAGW-1:0] tags;
  logic [ENTRIES-1:0]           probe_match;
  logic [ENTRIES-1:0]           ins_match;
  logic [ENTRIES-1:0]           free_slots;
  logic [ENTRIES-1:0]           pick;
  logic                         do_ins;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign probe_match[g] = vld[g] && (tags[g] == probe_tag);
    assign ins_match[g]   = vld[g] && (tags[g] == ins_tag);
  end

  assign probe_hit   = |probe_match;
  assign ins_present = |ins_match;
  assign full        = &vld;
  assign free_slots  = ~vld;
  assign pick        = free_slots & (~free_slots + 1'b1);
  assign do_ins      = ins_en && !clr && !ins_present && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (do_ins) begin
      vld <= vld | pick;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (do_ins && pick[i]) tags[i] <= ins_tag;
    end
  end

  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_match) && $onehot0(ins_match)); // R6
  AST_INSERT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    do_ins |=> ($countones(vld) == $countones($past(vld)) + 1)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !probe_hit && !ins_present); // R8
endmodule

// File: rtl/txn_abort_arb.sv
// Fixed-priority selection among simultaneous abort reasons.
module txn_abort_arb
  import txn_pkg::*;
(
  input  logic         conflict,
  input  logic         capacity,
  input  logic         external,
  input  logic         explicit,
  output logic         any,
  output abort_cause_e cause
);
  always_comb begin
    any = conflict || capacity || external || explicit;
    if (conflict)      cause = CAUSE_CONFLICT;
    else if (capacity) cause = CAUSE_CAPACITY;
    else if (external) cause = CAUSE_EXTERNAL;
    else               cause = CAUSE_EXPLICIT;
  end

  always_comb begin
    if (external && !conflict && !capacity)
      AST_EXT_OVER_EXPL: assert (cause == CAUSE_EXTERNAL); // R11
  end
endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import txn_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 6,
  parameter int ENTRIES   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_begin,
  input  logic          txn_commit,
  input  logic          txn_abort_req,
  input  logic          txn_abort_ext,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  output logic          abort_pulse,
  output logic [1:0]    abort_cause,
  output logic          end_clear
);
  localparam int TAGW = AW - LINE_BITS;

  logic            active;
  logic [TAGW-1:0] acc_tag, snp_tag;
  logic            rd_hit, rd_present, rd_full;
  logic            wr_hit, wr_present, wr_full;
  logic            rd_ins, wr_ins;
  logic            snp_conflict, cap_abort, ext_abort, expl_abort;
  logic            any_abort, ending;
  abort_cause_e    sel_cause;

  assign acc_tag = acc_addr[AW-1:LINE_BITS];
  assign snp_tag = snp_addr[AW-1:LINE_BITS];

  assign snp_conflict = active && snp_valid && (wr_hit || (snp_write && rd_hit));
  assign cap_abort    = active && acc_valid &&
                        (acc_write ? (!wr_present && wr_full) : (!rd_present && rd_full));
  assign ext_abort    = active && txn_abort_ext;
  assign expl_abort   = active && txn_abort_req;
  assign ending       = active && (any_abort || txn_commit);
  assign rd_ins       = active && acc_valid && !acc_write;
  assign wr_ins       = active && acc_valid && acc_write;

  txn_line_set #(.ENTRIES(ENTRIES), .TAGW(TAGW)) i_rd_set (
    .clk(clk), .rst_n(rst_n), .clr(ending), .ins_en(rd_ins), .ins_tag(acc_tag),
    .probe_tag(snp_tag), .probe_hit(rd_hit), .ins_present(rd_present), .full(rd_full)
  );

  txn_line_set #(.ENTRIES(ENTRIES), .TAGW(TAGW)) i_wr_set (
    .clk(clk), .rst_n(rst_n), .clr(ending), .ins_en(wr_ins), .ins_tag(acc_tag),
    .probe_tag(snp_tag), .probe_hit(wr_hit), .ins_present(wr_present), .full(wr_full)
  );

  txn_abort_arb i_arb (
    .conflict(snp_conflict), .capacity(cap_abort), .external(ext_abort),
    .explicit(expl_abort), .any(any_abort), .cause(sel_cause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      abort_pulse <= 1'b0;
      abort_cause <= CAUSE_CONFLICT;
      end_clear   <= 1'b0;
    end else begin
      abort_pulse <= active && any_abort;
      end_clear   <= ending;
      if (active && any_abort) abort_cause <= sel_cause;
      if (!active)     active <= txn_begin;
      else if (ending) active <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !abort_pulse && !end_clear); // R9
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> end_clear); // R8
  AST_READ_SNOOP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && snp_valid && !snp_write && wr_hit) |=>
      abort_pulse && abort_cause == CAUSE_CONFLICT); // R2
  AST_WRITE_SNOOP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && snp_valid && snp_write && (rd_hit || wr_hit)) |=>
      abort_pulse && abort_cause == CAUSE_CONFLICT); // R4
  AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_abort && !snp_conflict) |=> abort_pulse && abort_cause == CAUSE_CAPACITY); // R6
  AST_COMMIT_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && txn_commit && snp_conflict) |=> abort_pulse); // R10
  AST_REGION_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ending |=> !active); // R8
endmodule

// File: tb/test_txn_set_tracker.sv
`timescale 1ns/1ps
module test_txn_set_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b, c, x, e, av, aw, sv, sw;
  logic [31:0] aa, sa;
  logic ab_p, clr_p;
  logic [1:0] cause;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  txn_set_tracker i_txn_set_tracker (
    .clk(clk), .rst_n(rst_n), .txn_begin(b), .txn_commit(c), .txn_abort_req(x),
    .txn_abort_ext(e), .acc_valid(av), .acc_write(aw), .acc_addr(aa),
    .snp_valid(sv), .snp_write(sw), .snp_addr(sa),
    .abort_pulse(ab_p), .abort_cause(cause), .end_clear(clr_p)
  );

  typedef struct packed {
    logic [3:0]  ctl;   // begin, commit, explicit, external
    logic [1:0]  acc;   // valid, write
    logic [31:0] aa;
    logic [1:0]  snp;   // valid, write
    logic [31:0] sa;
    logic        ea;
    logic [1:0]  ec;
    logic        ecl;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd8},  // R8 open
    '{4'b0000, 2'b10, 32'h1000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd3},
    '{4'b0000, 2'b11, 32'h2000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd2},
    '{4'b0000, 2'b00, 32'h0,    2'b10, 32'h1008, 1'b0, 2'd0, 1'b0, 8'd3},  // R3
    '{4'b0000, 2'b00, 32'h0,    2'b10, 32'h2030, 1'b1, 2'd0, 1'b1, 8'd2},  // R2 R5
    '{4'b0000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd8},
    '{4'b0000, 2'b00, 32'h0,    2'b11, 32'h2000, 1'b0, 2'd0, 1'b0, 8'd9},  // R9
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd4},
    '{4'b0000, 2'b10, 32'h3000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd4},
    '{4'b0000, 2'b00, 32'h0,    2'b11, 32'h303F, 1'b1, 2'd0, 1'b1, 8'd4},  // R4 R5
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd4},
    '{4'b0000, 2'b11, 32'h4000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd4},
    '{4'b0000, 2'b00, 32'h0,    2'b11, 32'h4004, 1'b1, 2'd0, 1'b1, 8'd4},  // R4
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd8},
    '{4'b0000, 2'b11, 32'h5000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd8},
    '{4'b0100, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b1, 8'd8},  // R8 commit
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd8},
    '{4'b0000, 2'b00, 32'h0,    2'b11, 32'h5000, 1'b0, 2'd0, 1'b0, 8'd8},  // R8 old line gone
    '{4'b0000, 2'b11, 32'h6000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd10},
    '{4'b0100, 2'b00, 32'h0,    2'b10, 32'h6010, 1'b1, 2'd0, 1'b1, 8'd10}, // R10
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd7},
    '{4'b0001, 2'b00, 32'h0,    2'b00, 32'h0,    1'b1, 2'd2, 1'b1, 8'd7},  // R7 external
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd7},
    '{4'b0010, 2'b00, 32'h0,    2'b00, 32'h0,    1'b1, 2'd3, 1'b1, 8'd7},  // R7 explicit
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd11},
    '{4'b0000, 2'b10, 32'h7000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd11},
    '{4'b0011, 2'b00, 32'h0,    2'b11, 32'h7000, 1'b1, 2'd0, 1'b1, 8'd11}, // R11
    '{4'b1000, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd5},
    '{4'b0000, 2'b10, 32'h8000, 2'b00, 32'h0,    1'b0, 2'd0, 1'b0, 8'd5},
    '{4'b0000, 2'b00, 32'h0,    2'b11, 32'h8040, 1'b0, 2'd0, 1'b0, 8'd5},  // R5 adjacent
    '{4'b0100, 2'b00, 32'h0,    2'b00, 32'h0,    1'b0, 2'd0, 1'b1, 8'd8}
  };

  task automatic chk(input int req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] ctl, input logic [1:0] acc, input logic [31:0] a_addr,
                      input logic [1:0] snp, input logic [31:0] s_addr);
    @(negedge clk);
    {b, c, x, e} = ctl;
    {av, aw} = acc;
    aa = a_addr;
    {sv, sw} = snp;
    sa = s_addr;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input int req, input logic ea, input logic [1:0] ec, input logic ecl);
    chk(req, "abort_pulse", int'(ab_p), int'(ea));
    chk(req, "end_clear", int'(clr_p), int'(ecl));
    if (ea) chk(req, "abort_cause", int'(cause), int'(ec));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    {b, c, x, e, av, aw, sv, sw} = '0;
    aa = '0;
    sa = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: outputs quiet after reset
    expect_out(1, 1'b0, 2'd0, 1'b0);
    step(4'b0000, 2'b00, 0, 2'b11, 32'h0);
    expect_out(1, 1'b0, 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ctl, TBL[i].acc, TBL[i].aa, TBL[i].snp, TBL[i].sa);
      expect_out(int'(TBL[i].req), TBL[i].ea, TBL[i].ec, TBL[i].ecl);
    end

    // R9: access while idle is not recorded
    step(4'b0000, 2'b11, 32'h9000, 2'b00, 0);
    step(4'b1000, 2'b00, 0, 2'b00, 0);
    step(4'b0000, 2'b00, 0, 2'b11, 32'h9000);
    expect_out(9, 1'b0, 2'd0, 1'b0);
    // R9: begin while open is ignored, region stays open
    step(4'b1000, 2'b00, 0, 2'b00, 0);
    expect_out(9, 1'b0, 2'd0, 1'b0);
    step(4'b0100, 2'b00, 0, 2'b00, 0);
    expect_out(9, 1'b0, 2'd0, 1'b1);

    // R6: sixteen distinct lines fit, a repeat uses no entry, the seventeenth aborts
    step(4'b1000, 2'b00, 0, 2'b00, 0);
    for (int k = 0; k < 16; k++) begin
      step(4'b0000, 2'b10, 32'h10000 + k * 64, 2'b00, 0);
      expect_out(6, 1'b0, 2'd0, 1'b0);
    end
    step(4'b0000, 2'b10, 32'h10004, 2'b00, 0);
    expect_out(6, 1'b0, 2'd0, 1'b0);
    step(4'b0000, 2'b10, 32'h20000, 2'b00, 0);
    expect_out(6, 1'b1, 2'd1, 1'b1);

    // R11: capacity outranks external in the same cycle (write set)
    step(4'b1000, 2'b00, 0, 2'b00, 0);
    for (int k = 0; k < 16; k++) step(4'b0000, 2'b11, 32'h30000 + k * 64, 2'b00, 0);
    expect_out(11, 1'b0, 2'd0, 1'b0);
    step(4'b0001, 2'b11, 32'h40000, 2'b00, 0);
    expect_out(11, 1'b1, 2'd1, 1'b1);
    // R8: the strobe lasts one cycle
    step(4'b0000, 2'b00, 0, 2'b00, 0);
    expect_out(8, 1'b0, 2'd0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule